// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the refresh duties for an asynchronous DRAM with 2^ROW_BITS rows. It leaves reset in a quiet power-up pause that lasts longer than the minimum wait. It then runs a fixed burst of dummy refresh cycles to bring the array's internal circuits up. After that it raises `init_done` and refreshes the part at evenly spaced intervals, so that every row is visited once per retention period. All cycle counts are derived at elaboration from the clock rate and from timing figures given in nanoseconds or microseconds.

The sequencer shares the DRAM pins with an access controller. Before each refresh it raises `bus_req`. It drives the strobes only after `bus_gnt` is seen and while `strobe_oe` is high. A refresh that falls due while the bus is withheld is owed. Owed refreshes are counted up to `MAX_OWED` and are replayed back to back once the grant arrives. By default a refresh lowers both CAS strobes before RAS, so the DRAM supplies the row from its own counter. With `RAS_ONLY` set, the block puts its own wrapping row number on the address and pulses RAS alone. The access side's bus requests are gated off until initialization is complete.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n`, `ucas_n` and `lcas_n` are high and `bus_req` and `init_done` are low. After reset is released, `bus_req` and all strobes stay idle for PAUSE_CYC = floor(PAUSE_US*CLK_KHZ/1000)+1 cycles. The first `bus_req` follows within two further cycles.
- R2: Exactly DUMMY_CYCLES refresh cycles (one RAS low pulse each) complete before `init_done` rises. Once `init_done` is high it stays high until reset.
- R3: `acc_req_out` equals `acc_req_in` AND `init_done` in every cycle, so it is low for the whole initialization.
- R4: With RAS_ONLY=0, both CAS strobes are already low in the cycle before RAS falls, and they stay low on the RAS falling edge.
- R5: With RAS_ONLY=1, `ucas_n` and `lcas_n` are never driven low.
- R6: Each RAS low pulse lasts exactly ACT_CYC = max(ceil(TRAS_NS), ceil(TRC_NS)-ceil(TRP_NS)) clocks. RAS is high for at least ceil(TRP_NS) clocks before it falls again, and the spacing from one RAS fall to the next is at least ceil(TRC_NS) clocks. All of these are in cycles of the input clock.
- R7: Once initialization is over and the bus is granted freely, RAS falls exactly INTERVAL_CYC = floor(floor(RETENTION_US*CLK_KHZ/1000) / 2^ROW_BITS) cycles apart.
- R8: A strobe is low only while `strobe_oe` is high, and `strobe_oe` rises only after `bus_gnt` was high in the previous cycle. While the grant is withheld, no RAS pulse occurs and `bus_req` stays high.
- R9: Refreshes that fall due without a grant are owed, with the count saturating at MAX_OWED. On grant, all owed refreshes are issued with RAS falls exactly LEAD_CYC+ACT_CYC+PRE_CYC+1 cycles apart. With the bench timing this spacing is 10 cycles.
- R10: With RAS_ONLY=1, `dram_addr` at the k-th RAS fall after reset equals k mod 2^ROW_BITS, counting from 0. The dummy cycles are included in k. The address does not change while RAS is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_gnt | input | 1 | Grant of the DRAM pins to this block |
| acc_req_in | input | 1 | Bus request from the access side |
| bus_req | output | 1 | Request for the DRAM pins; held until refresh work is drained |
| strobe_oe | output | 1 | High while this block drives strobes and address |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_addr | output | ROW_BITS | Row address in RAS-only mode, zero otherwise |
| init_done | output | 1 | Power-up pause and dummy burst complete |
| acc_req_out | output | 1 | Access-side request, gated by `init_done` |

## Verification
Two configurations are used, each with a shortened retention period: one in CAS-before-RAS mode with 16 rows and one in RAS-only mode with 8 rows. The CAS-before-RAS instance is first run with the grant always given. This shows the pause length, the dummy count and the steady refresh spacing apart from one another. The grant is then withheld for three intervals and later for six. The first window checks that owed refreshes are replayed back to back in full. The second shows that the owed count saturates at four. The RAS-only instance runs through more than two full address wraps, which checks sequential addressing, the wrap point and that CAS stays high.

// File: rtl/dref_pkg.sv
// Shared types and helpers for the DRAM refresh sequencer.
// Assumes clock rates are given in kHz and delays in ns.
package dref_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,   // power-up wait
        ST_IDLE,    // nothing owed
        ST_REQ,     // requesting the bus
        ST_LEAD,    // strobe setup before RAS falls
        ST_ACT,     // RAS low
        ST_PRE      // precharge, RAS high
    } seq_state_e;

    // Smallest number of clock cycles covering a delay in ns.
    function automatic int ns_to_cyc(input int ns, input int khz);
        longint prod;
        prod = longint'(ns) * longint'(khz);
        return int'((prod + 64'sd999999) / 64'sd1000000);
    endfunction

endpackage

// File: rtl/dref_timebase.sv
// Time base: times the power-up pause and emits one tick per refresh interval.
// Assumes pause_run is high only in the pause state, ivl_run stays high once set.
module dref_timebase #(
    parameter int PAUSE_CYC    = 10001,
    parameter int INTERVAL_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_run,
    input  logic ivl_run,
    output logic pause_done,
    output logic ivl_tick
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int IW = $clog2(INTERVAL_CYC + 1);

    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] ivl_cnt;

    assign pause_done = pause_run && (pause_cnt == PW'(PAUSE_CYC - 1));
    assign ivl_tick   = ivl_run && (ivl_cnt == IW'(INTERVAL_CYC - 1));

    // Count cycles spent in the power-up pause.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pause_cnt <= '0;
        else if (pause_run && !pause_done)
            pause_cnt <= pause_cnt + 1'b1;
    end

    // Free-running interval counter once initialization has finished.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ivl_cnt <= '0;
        else if (ivl_run)
            ivl_cnt <= ivl_tick ? '0 : ivl_cnt + 1'b1;
    end

endmodule

// File: rtl/dref_work_ctr.sv
// Work bookkeeping: dummy cycles left during init, owed refreshes afterwards.
// Assumes cycle_done pulses for one clock at the end of every refresh cycle.
module dref_work_ctr #(
    parameter int DUMMY_CYCLES = 8,
    parameter int MAX_OWED     = 4,
    parameter int OWED_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cycle_done,
    output logic              init_done,
    output logic              work,
    output logic              more_work,
    output logic [OWED_W-1:0] owed
);
    localparam int DW = $clog2(DUMMY_CYCLES + 1);

    logic [DW-1:0]     dummy_left;
    logic [OWED_W-1:0] owed_dec;

    // Count down the dummy burst and flag completion after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dummy_left <= DW'(DUMMY_CYCLES);
            init_done  <= 1'b0;
        end else if (!init_done && cycle_done) begin
            dummy_left <= dummy_left - 1'b1;
            if (dummy_left == DW'(1))
                init_done <= 1'b1;
        end
    end

    // Owed count after a completed refresh is taken off.
    always_comb begin
        owed_dec = owed;
        if (init_done && cycle_done && owed != '0)
            owed_dec = owed - 1'b1;
    end

    // Add a due refresh unless the owed count is saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owed <= '0;
        else if (tick && owed_dec != OWED_W'(MAX_OWED))
            owed <= owed_dec + 1'b1;
        else
            owed <= owed_dec;
    end

    assign work      = init_done ? (owed != '0) : (dummy_left != '0);
    assign more_work = init_done ? (owed > OWED_W'(1)) : (dummy_left > DW'(1));

endmodule

// File: rtl/dref_strobe_seq.sv
// Strobe sequencer: requests the bus, then plays lead, RAS-low and precharge
// phases. RAS_ONLY selects the ordering and whether a row counter drives addr.
// Assumes bus_gnt is held for the whole cycle once given.
module dref_strobe_seq
    import dref_pkg::*;
#(
    parameter int LEAD_CYC = 1,
    parameter int ACT_CYC  = 5,
    parameter int PRE_CYC  = 3,
    parameter bit RAS_ONLY = 1'b0,
    parameter int ROW_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pause_done,
    input  logic                work,
    input  logic                more_work,
    input  logic                bus_gnt,
    output seq_state_e          state,
    output logic                cycle_done,
    output logic                bus_req,
    output logic                strobe_oe,
    output logic                ras_n,
    output logic                ucas_n,
    output logic                lcas_n,
    output logic [ROW_BITS-1:0] row_addr
);
    localparam int MAXC = (LEAD_CYC > ACT_CYC) ?
                          ((LEAD_CYC > PRE_CYC) ? LEAD_CYC : PRE_CYC) :
                          ((ACT_CYC > PRE_CYC) ? ACT_CYC : PRE_CYC);
    localparam int CW = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    assign cycle_done = (state == ST_PRE) && (cnt == '0);

    // Phase state machine with a down-counter per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_PAUSE: if (pause_done) state <= ST_IDLE;
                ST_IDLE:  if (work) state <= ST_REQ;
                ST_REQ: if (bus_gnt) begin
                    state <= ST_LEAD;
                    cnt   <= CW'(LEAD_CYC - 1);
                end
                ST_LEAD: if (cnt == '0) begin
                    state <= ST_ACT;
                    cnt   <= CW'(ACT_CYC - 1);
                end else cnt <= cnt - 1'b1;
                ST_ACT: if (cnt == '0) begin
                    state <= ST_PRE;
                    cnt   <= CW'(PRE_CYC - 1);
                end else cnt <= cnt - 1'b1;
                ST_PRE: if (cnt == '0) state <= more_work ? ST_REQ : ST_IDLE;
                        else cnt <= cnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_req   = (state == ST_REQ) || (state == ST_LEAD) ||
                       (state == ST_ACT) || (state == ST_PRE);
    assign strobe_oe = (state == ST_LEAD) || (state == ST_ACT) || (state == ST_PRE);
    assign ras_n     = (state != ST_ACT);

    generate
        if (RAS_ONLY) begin : g_ras_only
            logic [ROW_BITS-1:0] row_q;
            // Own row counter, one step per finished refresh, wraps naturally.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    row_q <= '0;
                else if (cycle_done)
                    row_q <= row_q + 1'b1;
            end
            assign row_addr = row_q;
            assign ucas_n   = 1'b1;
            assign lcas_n   = 1'b1;
        end else begin : g_cbr
            logic cas_on;
            assign cas_on   = (state == ST_LEAD) || (state == ST_ACT);
            assign row_addr = '0;
            assign ucas_n   = !cas_on;
            assign lcas_n   = !cas_on;
        end
    endgenerate

endmodule

// File: rtl/dram_refresh_seq.sv
// Top of the DRAM refresh sequencer: power-up pause, dummy burst, then
// evenly spaced refresh with bus arbitration and owed-refresh replay.
// Assumes a single clock; all timing derived from CLK_KHZ at elaboration.
module dram_refresh_seq
    import dref_pkg::*;
#(
    parameter int CLK_KHZ      = 100000,
    parameter int PAUSE_US     = 100,
    parameter int RETENTION_US = 16000,
    parameter int ROW_BITS     = 10,
    parameter int DUMMY_CYCLES = 8,
    parameter int MAX_OWED     = 4,
    parameter bit RAS_ONLY     = 1'b0,
    parameter int TRC_NS       = 75,
    parameter int TRP_NS       = 25,
    parameter int TRAS_NS      = 40,
    parameter int TLEAD_NS     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_gnt,
    input  logic                acc_req_in,
    output logic                bus_req,
    output logic                strobe_oe,
    output logic                ras_n,
    output logic                ucas_n,
    output logic                lcas_n,
    output logic [ROW_BITS-1:0] dram_addr,
    output logic                init_done,
    output logic                acc_req_out
);
    localparam int PAUSE_CYC    = int'((longint'(PAUSE_US) * CLK_KHZ) / 1000 + 1);
    localparam int ROWS         = 1 << ROW_BITS;
    localparam int INTERVAL_CYC = int'(((longint'(RETENTION_US) * CLK_KHZ) / 1000) / ROWS);
    localparam int PRE_CYC      = ns_to_cyc(TRP_NS, CLK_KHZ);
    localparam int TRC_CYC      = ns_to_cyc(TRC_NS, CLK_KHZ);
    localparam int RAS_MIN      = ns_to_cyc(TRAS_NS, CLK_KHZ);
    localparam int ACT_CYC      = (RAS_MIN > TRC_CYC - PRE_CYC) ? RAS_MIN : TRC_CYC - PRE_CYC;
    localparam int LEAD_RAW     = ns_to_cyc(TLEAD_NS, CLK_KHZ);
    localparam int LEAD_CYC     = (LEAD_RAW < 1) ? 1 : LEAD_RAW;
    localparam int OWED_W       = $clog2(MAX_OWED + 1);

    seq_state_e        state;
    logic              in_pause;
    logic              pause_done;
    logic              ivl_tick;
    logic              cycle_done;
    logic              work;
    logic              more_work;
    logic [OWED_W-1:0] owed;

    assign in_pause    = (state == ST_PAUSE);
    assign acc_req_out = acc_req_in && init_done;

    dref_timebase #(
        .PAUSE_CYC    (PAUSE_CYC),
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_run  (in_pause),
        .ivl_run    (init_done),
        .pause_done (pause_done),
        .ivl_tick   (ivl_tick)
    );

    dref_work_ctr #(
        .DUMMY_CYCLES (DUMMY_CYCLES),
        .MAX_OWED     (MAX_OWED),
        .OWED_W       (OWED_W)
    ) u_work (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (ivl_tick),
        .cycle_done (cycle_done),
        .init_done  (init_done),
        .work       (work),
        .more_work  (more_work),
        .owed       (owed)
    );

    dref_strobe_seq #(
        .LEAD_CYC (LEAD_CYC),
        .ACT_CYC  (ACT_CYC),
        .PRE_CYC  (PRE_CYC),
        .RAS_ONLY (RAS_ONLY),
        .ROW_BITS (ROW_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_done (pause_done),
        .work       (work),
        .more_work  (more_work),
        .bus_gnt    (bus_gnt),
        .state      (state),
        .cycle_done (cycle_done),
        .bus_req    (bus_req),
        .strobe_oe  (strobe_oe),
        .ras_n      (ras_n),
        .ucas_n     (ucas_n),
        .lcas_n     (lcas_n),
        .row_addr   (dram_addr)
    );

endmodule

// File: rtl/dref_checker.sv
// Protocol checker for dram_refresh_seq, attached with bind below.
// Assumes synchronous active-low reset; all properties disabled during it.
module dref_checker #(
    parameter bit RAS_ONLY = 1'b0,
    parameter int ROW_BITS = 10,
    parameter int MAX_OWED = 4,
    parameter int OWED_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_gnt,
    input logic                bus_req,
    input logic                strobe_oe,
    input logic                ras_n,
    input logic                ucas_n,
    input logic                lcas_n,
    input logic [ROW_BITS-1:0] dram_addr,
    input logic                init_done,
    input logic                acc_req_out,
    input logic                in_pause,
    input logic [OWED_W-1:0]   owed
);
    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_pause |-> (!bus_req && ras_n && ucas_n && lcas_n)); // R1

    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R2

    AST_ACC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !acc_req_out); // R3

    AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !ucas_n || !lcas_n) |-> strobe_oe); // R8

    AST_OE_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_oe) |-> $past(bus_gnt)); // R8

    AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OWED_W'(MAX_OWED)); // R9

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> $stable(dram_addr)); // R10

    generate
        if (!RAS_ONLY) begin : g_cbr_chk
            AST_CAS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ras_n) |-> (!ucas_n && !lcas_n && $past(!ucas_n && !lcas_n))); // R4
        end
    endgenerate

endmodule

bind dram_refresh_seq dref_checker #(
    .RAS_ONLY (RAS_ONLY),
    .ROW_BITS (ROW_BITS),
    .MAX_OWED (MAX_OWED),
    .OWED_W   (OWED_W)
) u_dref_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_gnt     (bus_gnt),
    .bus_req     (bus_req),
    .strobe_oe   (strobe_oe),
    .ras_n       (ras_n),
    .ucas_n      (ucas_n),
    .lcas_n      (lcas_n),
    .dram_addr   (dram_addr),
    .init_done   (init_done),
    .acc_req_out (acc_req_out),
    .in_pause    (in_pause),
    .owed        (owed)
);

// File: tb/dram_refresh_seq_bench.sv
`timescale 1ns/1ps
// Bench: CAS-before-RAS instance with grant control, RAS-only instance always granted.
module dram_refresh_seq_bench;
    localparam int PAUSE_CYC = 201;
    localparam int ACT_CYC   = 5;
    localparam int PRE_CYC   = 3;
    localparam int TRC_CYC   = 8;
    localparam int C_IVL     = 400;
    localparam int B2B_GAP   = 10;
    localparam int R_ROWS    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt_en = 1'b1;
    logic acc_req_in = 1'b0;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    logic       c_gnt, c_req, c_oe, c_ras_n, c_ucas_n, c_lcas_n, c_init, c_acc;
    logic [3:0] c_addr;
    logic       r_gnt, r_req, r_oe, r_ras_n, r_ucas_n, r_lcas_n, r_init, r_acc;
    logic [2:0] r_addr;

    assign c_gnt = c_req & gnt_en;
    assign r_gnt = r_req;

    dram_refresh_seq #(
        .CLK_KHZ(100000), .PAUSE_US(2), .RETENTION_US(64), .ROW_BITS(4),
        .MAX_OWED(4), .RAS_ONLY(1'b0)
    ) u_dram_refresh_seq (
        .clk(clk), .rst_n(rst_n), .bus_gnt(c_gnt), .acc_req_in(acc_req_in),
        .bus_req(c_req), .strobe_oe(c_oe), .ras_n(c_ras_n), .ucas_n(c_ucas_n),
        .lcas_n(c_lcas_n), .dram_addr(c_addr), .init_done(c_init), .acc_req_out(c_acc)
    );

    dram_refresh_seq #(
        .CLK_KHZ(100000), .PAUSE_US(2), .RETENTION_US(16), .ROW_BITS(3),
        .MAX_OWED(4), .RAS_ONLY(1'b1)
    ) u_dram_refresh_seq_ro (
        .clk(clk), .rst_n(rst_n), .bus_gnt(r_gnt), .acc_req_in(acc_req_in),
        .bus_req(r_req), .strobe_oe(r_oe), .ras_n(r_ras_n), .ucas_n(r_ucas_n),
        .lcas_n(r_lcas_n), .dram_addr(r_addr), .init_done(r_init), .acc_req_out(r_acc)
    );

    initial forever #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Access-side request pattern, changed well away from both edges.
    initial forever begin
        @(posedge clk);
        #2;
        acc_req_in = ((cyc % 3) != 0);
    end

    // Monitor state
    int  c_falls = 0, c_last_fall = -1, c_gap = 0, c_low_run = 0, c_high_run = 1000;
    int  c_order_err = 0, c_act_err = 0, c_pre_err = 0, c_trc_err = 0, c_oe_err = 0;
    int  acc_err = 0, init_falls = -1;
    int  r_falls = 0, r_addr_err = 0, r_cas_err = 0;
    logic c_ras_prev = 1'b1, r_ras_prev = 1'b1, c_init_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!c_ras_n && c_ras_prev) begin
                if (c_ucas_n || c_lcas_n) c_order_err++;
                if (c_high_run < PRE_CYC) c_pre_err++;
                if (c_last_fall >= 0) begin
                    c_gap = cyc - c_last_fall;
                    if (c_gap < TRC_CYC) c_trc_err++;
                end
                c_last_fall = cyc;
                c_falls++;
                c_low_run = 1;
            end else if (!c_ras_n) begin
                c_low_run++;
            end else if (!c_ras_prev) begin
                if (c_low_run != ACT_CYC) c_act_err++;
                c_high_run = 1;
            end else begin
                c_high_run++;
            end
            if ((!c_ras_n || !c_ucas_n || !c_lcas_n) && !c_oe) c_oe_err++;
            if (c_acc !== (acc_req_in && c_init)) acc_err++;
            if (r_acc !== (acc_req_in && r_init)) acc_err++;
            if (c_init && !c_init_prev) init_falls = c_falls;
            if (!r_ucas_n || !r_lcas_n) r_cas_err++;
            if (!r_ras_n && r_ras_prev) begin
                if (int'(r_addr) != (r_falls % R_ROWS)) r_addr_err++;
                r_falls++;
            end
            c_ras_prev  = c_ras_n;
            r_ras_prev  = r_ras_n;
            c_init_prev = c_init;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int n;
        int f0;
        step(5);
        // R1 reset state
        check(c_ras_n && c_ucas_n && c_lcas_n && r_ras_n, "R1", "strobes in reset",
              {c_ras_n, c_ucas_n, c_lcas_n, r_ras_n}, 15);
        check(!c_req && !c_init && !r_req, "R1", "req/init in reset",
              {c_req, c_init, r_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (!c_req) begin
            @(negedge clk);
            #1;
            n++;
        end
        check(n >= PAUSE_CYC && n <= PAUSE_CYC + 2, "R1", "cycles to first request",
              n, PAUSE_CYC + 1);
        check(c_falls == 0, "R1", "RAS pulses during pause", c_falls, 0);
        while (!c_init) step(1);
        check(init_falls == 8, "R2", "dummy cycles before init_done", init_falls, 8);
        check(acc_err == 0, "R3", "acc gating mismatches", acc_err, 0);
        // R7 steady spacing
        while (c_falls < 10) step(1);
        check(c_gap == C_IVL, "R7", "refresh spacing 9-10", c_gap, C_IVL);
        while (c_falls < 11) step(1);
        check(c_gap == C_IVL, "R7", "refresh spacing 10-11", c_gap, C_IVL);
        check(c_init, "R2", "init_done held", c_init, 1);
        // R8/R9 withhold for three intervals
        step(20);
        gnt_en = 1'b0;
        f0 = c_falls;
        step(3 * C_IVL);
        check(c_falls == f0, "R8", "RAS pulses without grant", c_falls - f0, 0);
        check(c_req, "R8", "request pending", c_req, 1);
        check(!c_oe, "R8", "strobe_oe without grant", c_oe, 0);
        gnt_en = 1'b1;
        step(100);
        check(c_falls - f0 == 3, "R9", "owed replayed", c_falls - f0, 3);
        check(c_gap == B2B_GAP, "R9", "back-to-back spacing", c_gap, B2B_GAP);
        // R9 saturation: withhold for six intervals
        f0 = c_falls;
        while (c_falls == f0) step(1);
        step(20);
        gnt_en = 1'b0;
        f0 = c_falls;
        step(6 * C_IVL);
        check(c_falls == f0, "R8", "RAS pulses without grant (long)", c_falls - f0, 0);
        gnt_en = 1'b1;
        step(100);
        check(c_falls - f0 == 4, "R9", "saturated owed count", c_falls - f0, 4);
        // RAS-only instance
        while (r_falls < 20) step(1);
        check(r_addr_err == 0, "R10", "row address mismatches", r_addr_err, 0);
        check(r_cas_err == 0, "R5", "CAS low in RAS-only mode", r_cas_err, 0);
        // Aggregate protocol checks on CAS-before-RAS instance
        check(c_order_err == 0, "R4", "CAS not low at RAS fall", c_order_err, 0);
        check(c_act_err == 0, "R6", "RAS low width errors", c_act_err, 0);
        check(c_pre_err == 0, "R6", "precharge too short", c_pre_err, 0);
        check(c_trc_err == 0, "R6", "cycle time too short", c_trc_err, 0);
        check(c_oe_err == 0, "R8", "strobe without strobe_oe", c_oe_err, 0);
        check(acc_err == 0, "R3", "acc gating mismatches (final)", acc_err, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule